// File: doc/BRIEF.md
# Set/Clear/Write Control Register

This block holds one control word, sized by a parameter (16 bits by default), and places it on a command bus at four adjacent addresses. A command comes in as a single-cycle strobe. With the strobe come a flag that says whether the command carries a data word, a 14-bit address and that data word. The two lowest address bits choose the operation. Other logic can set chosen bits, or clear chosen bits, without a read-modify-write of its own. It can also load the whole word, or only read it back. All four addresses share one read-back path.

Every command that hits the block's address window returns one response word in the cycle after the strobe. This word is the register value from before the command took effect. When the block gives no response, its response outputs are zero. Several such registers can therefore be OR-combined onto one response bus. The current register value is also driven out in parallel for the logic that the register controls. The base address is a parameter and must be a multiple of four.

Top module: `setclr_ctrl_reg`

## Requirements
- R1: A synchronous active-high reset clears the register to zero and holds the response strobe and response data at zero.
- R2: A matching command with a data word and low address bits 2'b10 sets every register bit whose data bit is 1 and leaves the other bits unchanged.
- R3: A matching command with a data word and low address bits 2'b01 clears every register bit whose data bit is 1 and leaves the other bits unchanged.
- R4: A matching command with a data word and low address bits 2'b11 loads the whole register from the data word.
- R5: A matching command with a data word and low address bits 2'b00 leaves the register unchanged.
- R6: A matching command without a data word leaves the register unchanged, whatever its low address bits are.
- R7: Every matching command, with or without a data word and at any of the four addresses, raises the response strobe for exactly one cycle, in the cycle after the command strobe.
- R8: The response data carries the register value from before the command, and it is zero in every cycle without a response.
- R9: A command whose address bits above bit 1 differ from those of the base address changes nothing and gives no response.
- R10: While the command strobe is low, the address, data and data-flag inputs have no effect on the register or the response outputs.
- R11: The parallel output always shows the current register value, and each change appears in the cycle after the command that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdStb | input | 1 | Command strobe, high for one cycle per command |
| cmdHasParam | input | 1 | High when the command carries a data word |
| cmdAddr | input | 14 | Command address; bits 1:0 select the operation |
| cmdData | input | 16 | Command data word |
| respStb | output | 1 | Response strobe, one cycle per matching command |
| respData | output | 16 | Response word: the register value before the command, zero otherwise |
| regValue | output | 16 | Parallel register output |

## Verification
The hardest case to reach from the ports is two matching commands on back-to-back cycles. There the second response must return the value that the first command wrote, while the first response still shows the value from before the first command. Random stimulus drives the strobe at high density around the base window, so such pairs of every operation occur often. Directed sequences add set-then-clear on overlapping bits, a data-less command at the full-write address, and addresses that differ from the base only in the upper bits.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_SET   = 2'b10,
    OP_LOAD  = 2'b11
  } regOp_t;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic hit;
    logic setEn;
    logic clrEn;
    logic loadEn;
  } regStrobe_t;

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 14'h0008
) (
  input  logic              cmdStb,
  input  logic              cmdHasParam,
  input  logic [ADDR_W-1:0] cmdAddr,
  output regStrobe_t        strobe
);

  localparam int PAGE_W = ADDR_W - 2;
  localparam logic [PAGE_W-1:0] BASE_PAGE = BASE_ADDR[ADDR_W-1:2];

  logic   pageMatch;
  logic   hit;
  regOp_t op;

  always_comb begin
    pageMatch = (cmdAddr[ADDR_W-1:2] == BASE_PAGE);
    hit       = cmdStb && pageMatch;
    op        = regOp_t'(cmdAddr[1:0]);
    strobe        = '0;
    strobe.hit    = hit;
    if (hit && cmdHasParam) begin
      unique case (op)
        OP_SET:   strobe.setEn  = 1'b1;
        OP_CLEAR: strobe.clrEn  = 1'b1;
        OP_LOAD:  strobe.loadEn = 1'b1;
        default:  ;
      endcase
    end
  end

  // at most one modifying strobe, and only with a hit
  always_comb begin
    AST_ONE_OP: assert ($countones({strobe.setEn, strobe.clrEn, strobe.loadEn}) <= 1); // R4
    AST_OP_NEEDS_HIT: assert (strobe.hit || !(strobe.setEn || strobe.clrEn || strobe.loadEn)); // R9
  end

endmodule

// File: rtl/ctlreg_datapath.sv
module ctlreg_datapath
  import ctlreg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] cmdData,
  output logic [DATA_W-1:0] regValue,
  output logic              respStb,
  output logic [DATA_W-1:0] respData
);

  logic [DATA_W-1:0] regQ;
  logic [DATA_W-1:0] regNext;

  // per-bit next-state selection
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      if (strobe.loadEn)
        regNext[b] = cmdData[b];
      else if (strobe.setEn && cmdData[b])
        regNext[b] = 1'b1;
      else if (strobe.clrEn && cmdData[b])
        regNext[b] = 1'b0;
      else
        regNext[b] = regQ[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regQ     <= '0;
      respStb  <= 1'b0;
      respData <= '0;
    end else begin
      regQ     <= regNext;
      respStb  <= strobe.hit;
      respData <= strobe.hit ? regQ : '0;
    end
  end

  assign regValue = regQ;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !respStb |-> respData == '0); // R8
  AST_RESP_OLD: assert property (@(posedge clk) disable iff (rst)
    strobe.hit |=> respStb && respData == $past(regQ)); // R8
  AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(strobe.hit || strobe.setEn || strobe.clrEn || strobe.loadEn) |=> $stable(regQ)); // R10

endmodule

// File: rtl/setclr_ctrl_reg.sv
module setclr_ctrl_reg
  import ctlreg_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 14'h0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdStb,
  input  logic              cmdHasParam,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              respStb,
  output logic [DATA_W-1:0] respData,
  output logic [DATA_W-1:0] regValue
);

  regStrobe_t strobe;

  ctlreg_decode #(
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) i_decode (
    .cmdStb(cmdStb),
    .cmdHasParam(cmdHasParam),
    .cmdAddr(cmdAddr),
    .strobe(strobe)
  );

  ctlreg_datapath #(
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .cmdData(cmdData),
    .regValue(regValue),
    .respStb(respStb),
    .respData(respData)
  );

  logic inWin;
  assign inWin = cmdStb && (cmdAddr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);

  AST_SET_BITS: assert property (@(posedge clk) disable iff (rst)
    inWin && cmdHasParam && cmdAddr[1:0] == 2'b10 |=> regValue == ($past(regValue) | $past(cmdData))); // R2
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
    inWin && cmdHasParam && cmdAddr[1:0] == 2'b01 |=> regValue == ($past(regValue) & ~$past(cmdData))); // R3
  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (rst)
    inWin && cmdHasParam && cmdAddr[1:0] == 2'b11 |=> regValue == $past(cmdData)); // R4
  AST_READ_KEEP: assert property (@(posedge clk) disable iff (rst)
    inWin && (!cmdHasParam || cmdAddr[1:0] == 2'b00) |=> $stable(regValue)); // R6
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    inWin |=> respStb); // R7
  AST_NO_RESP: assert property (@(posedge clk) disable iff (rst)
    !inWin |=> !respStb && $stable(regValue)); // R9

endmodule

// File: tb/test_setclr_ctrl_reg.sv
module test_setclr_ctrl_reg;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int DW = 16;
  localparam logic [AW-1:0] BASE = 14'h0008;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdStb = 1'b0;
  logic cmdHasParam = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic respStb;
  logic [DW-1:0] respData;
  logic [DW-1:0] regValue;

  int nChecks = 0;
  int nBad = 0;
  logic [DW-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  setclr_ctrl_reg #(.ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(BASE)) i_setclr_ctrl_reg (
    .clk(clk), .rst(rst), .cmdStb(cmdStb), .cmdHasParam(cmdHasParam),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .respStb(respStb),
    .respData(respData), .regValue(regValue)
  );

  function automatic logic isHit(logic s, logic [AW-1:0] a);
    return s && (a[AW-1:2] == BASE[AW-1:2]);
  endfunction

  function automatic logic [DW-1:0] nextVal(logic [DW-1:0] cur, logic s, logic p,
                                            logic [AW-1:0] a, logic [DW-1:0] d);
    if (!isHit(s, a) || !p) return cur;
    case (a[1:0])
      2'b10: return cur | d;
      2'b01: return cur & ~d;
      2'b11: return d;
      default: return cur;
    endcase
  endfunction

  function automatic string reqOf(logic s, logic p, logic [AW-1:0] a);
    if (!s) return "R10";
    if (!isHit(s, a)) return "R9";
    if (!p) return "R6";
    case (a[1:0])
      2'b10: return "R2";
      2'b01: return "R3";
      2'b11: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one cycle's command, then check outputs at the next falling edge
  task automatic step(logic s, logic p, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] old;
    logic hit;
    string req;
    old = model;
    hit = isHit(s, a);
    req = reqOf(s, p, a);
    cmdStb = s; cmdHasParam = p; cmdAddr = a; cmdData = d;
    model = nextVal(model, s, p, a, d);
    @(posedge clk);
    @(negedge clk);
    cmdStb = 1'b0;
    check(req, "regValue(R11)", regValue, model);
    check(hit ? "R7" : req, "respStb", {15'd0, respStb}, {15'd0, hit});
    check("R8", "respData", respData, hit ? old : '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    check("R1", "regValue reset", regValue, '0);
    check("R1", "respStb reset", {15'd0, respStb}, '0);
    check("R1", "respData reset", respData, '0);
    rst = 1'b0;

    // directed corner cases
    step(1, 1, BASE | 2'b11, 16'hA5C3);        // R4 full load
    step(1, 1, BASE | 2'b10, 16'h0F0F);        // R2 set
    step(1, 1, BASE | 2'b01, 16'h8181);        // R3 clear
    step(1, 1, BASE | 2'b00, 16'hFFFF);        // R5 read with data
    step(1, 0, BASE | 2'b11, 16'h0000);        // R6 no data at load address
    step(1, 0, BASE | 2'b01, 16'hFFFF);        // R6
    step(1, 1, BASE ^ 14'h0004, 16'h1234);     // R9 neighbour page
    step(1, 1, BASE ^ 14'h2000, 16'h0000);     // R9 top bit differs
    step(0, 1, BASE | 2'b11, 16'h0000);        // R10 strobe low
    step(1, 1, BASE | 2'b10, 16'hFFFF);        // back-to-back set then clear
    step(1, 1, BASE | 2'b01, 16'hFFFF);
    step(1, 1, BASE | 2'b11, 16'h0001);

    // random traffic around the window
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = (($urandom % 4) == 0) ? AW'($urandom) : (BASE | AW'($urandom % 4));
      step(($urandom % 4) != 0, ($urandom % 3) != 0, a, DW'($urandom));
    end

    // reset mid-run
    rst = 1'b1;
    model = '0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "regValue after reset", regValue, '0);
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule